// File: doc/BRIEF.md
# Load String Word Sequencer

This block carries out a load-string operation over several cycles. A caller presents a 32-bit instruction word together with the values of its two source registers and the current 7-bit byte-count value. If the word encodes one of the two load-string forms, the sequencer latches an effective address, a byte count and a first destination index. It then fetches the bytes one at a time through a byte-wide read port that allows one read in flight.

The fetched bytes are packed big-endian into 32-bit words. Each finished word, and a final partial word, leaves through a single register-file write port. Destination indices step up by one per word and wrap from 31 to 0. A one-cycle done pulse ends the operation. An indexed request that names clashing registers is refused with a one-cycle illegal pulse and has no other effect.

Top module: `lsw_seq`

## Requirements
- R1: A request is taken only when bits 31:26 equal 31, bit 0 is 0 and bits 10:1 equal 0x255 (immediate form) or 0x215 (indexed form). Any other word leaves the block idle, with no read, write, done or illegal pulse.
- R2: In the immediate form the count is bits 15:11, where 0 stands for 32. The start address is the rA value, or zero when bits 20:16 are 0.
- R3: In the indexed form the count is the 7-bit count input (0 to 127). The start address is (rA value, or zero when bits 20:16 are 0) plus the rB value.
- R4: Byte i is read from start address + i, in increasing order, one read at a time. The read address holds steady until read data is returned.
- R5: Within a word, the first byte lands in bits 31:24, then 23:16, 15:8 and 7:0. Bytes from earlier words never leak into a new word.
- R6: When the count is not a multiple of 4, the unfilled low bytes of the last written word are zero.
- R7: The first word goes to index bits 25:21. Each later word goes to the next index, wrapping from 31 to 0.
- R8: An indexed request where rD equals rA, or rD equals rB (bits 15:11), or rD and rA are both 0, pulses illegal for one cycle in the cycle after the request. It performs no read and no write and does not raise busy.
- R9: A legal request with a count of zero pulses done in the next cycle, with no read and no write.
- R10: A start request seen while busy is ignored and does not disturb the running transfer.
- R11: Exactly one write is issued per filled or final partial word. Done pulses in the cycle after the last write, and busy is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Request strobe, taken only while idle |
| instr | input | 32 | Instruction word of the request |
| ra_val | input | 32 | Value of the register named by bits 20:16 |
| rb_val | input | 32 | Value of the register named by bits 15:11 |
| xcnt | input | 7 | Byte-count value for the indexed form |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| illegal | output | 1 | One-cycle refusal pulse |
| rd_req | output | 1 | Byte read request, level while waiting |
| rd_addr | output | 32 | Byte read address |
| rd_valid | input | 1 | Read data valid this cycle |
| rd_data | input | 8 | Read data byte |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 5 | Register write index |
| wr_data | output | 32 | Register write data |

## Verification
Illegal and zero-count done pulses are due in the cycle right after the edge that takes the request. A byte is consumed at the edge where rd_valid is high, and the read address advances in the following cycle. A word's write appears in the cycle after its last byte is consumed, and done appears one cycle after the final write. The bench drives all inputs on the falling edge and samples every output shortly after it. It tracks the previous cycle's write strobe so that the done check pins the one-cycle gap exactly.

// File: rtl/lsw_pkg.sv
// Shared constants and types for the load-string sequencer.
// Assumes a 32-bit instruction word with the field layout given in the brief.
package lsw_pkg;
    localparam logic [5:0] OP_PRIMARY = 6'd31;
    localparam logic [9:0] XO_IMM     = 10'h255;
    localparam logic [9:0] XO_IDX     = 10'h215;
    localparam int unsigned IMM_W     = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_IMM  = 2'd1,
        FORM_IDX  = 2'd2
    } form_t;
endpackage

// File: rtl/lsw_decode.sv
// Combinational request decoder: recognises the two load-string forms,
// computes start address, byte count and first destination index, and
// flags register clashes of the indexed form.
// Assumes CNT_W is wide enough to hold both 32 and the largest count value.
module lsw_decode
    import lsw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int XCNT_W = 7,
    parameter int RIDX_W = 5,
    parameter int CNT_W  = XCNT_W + 1
) (
    input  logic [31:0]       instr,
    input  logic [ADDR_W-1:0] ra_val,
    input  logic [ADDR_W-1:0] rb_val,
    input  logic [XCNT_W-1:0] xcnt,
    output form_t             form,
    output logic [RIDX_W-1:0] dst_idx,
    output logic [ADDR_W-1:0] ea,
    output logic [CNT_W-1:0]  count,
    output logic              clash
);
    localparam int IMM_SPAN = 1 << IMM_W;

    logic [5:0]        op_f;
    logic [9:0]        xo_f;
    logic [RIDX_W-1:0] rd_f, ra_f, rb_f;
    logic [ADDR_W-1:0] base;

    // Field extraction from the instruction word.
    always_comb begin
        op_f = instr[31:26];
        rd_f = instr[25:21];
        ra_f = instr[20:16];
        rb_f = instr[15:11];
        xo_f = instr[10:1];
    end

    // Form recognition.
    always_comb begin
        form = FORM_NONE;
        if (op_f == OP_PRIMARY && !instr[0]) begin
            if (xo_f == XO_IMM)      form = FORM_IMM;
            else if (xo_f == XO_IDX) form = FORM_IDX;
        end
    end

    // Address, count and clash computation.
    always_comb begin
        base    = (ra_f == '0) ? '0 : ra_val;
        dst_idx = rd_f;
        if (form == FORM_IDX) begin
            ea    = base + rb_val;
            count = CNT_W'(xcnt);
            clash = (rd_f == ra_f) || (rd_f == rb_f) || (rd_f == '0 && ra_f == '0);
        end else begin
            ea    = base;
            count = (rb_f == '0) ? CNT_W'(IMM_SPAN) : CNT_W'(rb_f);
            clash = 1'b0;
        end
    end
endmodule

// File: rtl/lsw_pack.sv
// Big-endian word assembler. Lane 0 is bits DATA_W-1 downto DATA_W-8.
// A byte pushed into lane L keeps lanes above L from the accumulator and
// zeroes lanes below L, so entering lane 0 starts a fresh zeroed word.
// Assumes DATA_W is a multiple of 8.
module lsw_pack #(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        byte_in,
    output logic [DATA_W-1:0] merged
);
    logic [DATA_W-1:0] acc_q;

    // Per-lane merge of accumulator, new byte and zero fill.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[DATA_W-1-8*g -: 8] =
            (lane == LANE_W'(g)) ? byte_in :
            ((lane > LANE_W'(g)) ? acc_q[DATA_W-1-8*g -: 8] : 8'h00);
    end

    // Accumulator update on each consumed byte.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (push) acc_q <= merged;
    end

    // R5: a fresh word starts with only the new byte in the top lane.
    a_r5_fresh_word: assert property (@(posedge clk) disable iff (!rst_n)
        (push && lane == '0) |-> (merged[DATA_W-9:0] == '0));
endmodule

// File: rtl/lsw_seq.sv
// Load-string sequencer top. Takes a request while idle, then reads bytes
// one at a time over a request/valid port (one read in flight), packs them
// into words and writes each word once through a single register write port.
// Assumes the read port returns data for the current address only while
// rd_req is high, as a single-cycle rd_valid.
module lsw_seq
    import lsw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int XCNT_W = 7,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [31:0]       instr,
    input  logic [ADDR_W-1:0] ra_val,
    input  logic [ADDR_W-1:0] rb_val,
    input  logic [XCNT_W-1:0] xcnt,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data,
    output logic              wr_en,
    output logic [RIDX_W-1:0] wr_idx,
    output logic [DATA_W-1:0] wr_data
);
    localparam int CNT_W  = XCNT_W + 1;
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    form_t             dec_form;
    logic [RIDX_W-1:0] dec_dst;
    logic [ADDR_W-1:0] dec_ea;
    logic [CNT_W-1:0]  dec_cnt;
    logic              dec_clash;

    seq_state_t        state_q;
    logic [CNT_W-1:0]  byte_q, cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [RIDX_W-1:0] reg_q;
    logic              done_q, ill_q, wr_en_q;
    logic [RIDX_W-1:0] wr_idx_q;
    logic [DATA_W-1:0] wr_data_q;

    logic              accept, zero_go, capture, last_byte, word_full;
    logic [LANE_W-1:0] lane;
    logic [DATA_W-1:0] merged;

    lsw_decode #(.ADDR_W(ADDR_W), .XCNT_W(XCNT_W), .RIDX_W(RIDX_W), .CNT_W(CNT_W)) u_dec (
        .instr  (instr),
        .ra_val (ra_val),
        .rb_val (rb_val),
        .xcnt   (xcnt),
        .form   (dec_form),
        .dst_idx(dec_dst),
        .ea     (dec_ea),
        .count  (dec_cnt),
        .clash  (dec_clash)
    );

    lsw_pack #(.DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (capture),
        .lane   (lane),
        .byte_in(rd_data),
        .merged (merged)
    );

    // Handshake and position terms for the current cycle.
    always_comb begin
        accept    = start_valid && (state_q == ST_IDLE) && (dec_form != FORM_NONE);
        zero_go   = accept && !dec_clash && (dec_cnt == '0);
        capture   = (state_q == ST_READ) && rd_valid;
        lane      = byte_q[LANE_W-1:0];
        last_byte = ((byte_q + CNT_W'(1)) == cnt_q);
        word_full = (lane == LANE_W'(LANES - 1));
    end

    // Sequencer state, byte position, address and write issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            byte_q    <= '0;
            cnt_q     <= '0;
            addr_q    <= '0;
            reg_q     <= '0;
            done_q    <= 1'b0;
            ill_q     <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_idx_q  <= '0;
            wr_data_q <= '0;
        end else begin
            done_q  <= 1'b0;
            ill_q   <= 1'b0;
            wr_en_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (dec_clash) begin
                            ill_q <= 1'b1;
                        end else if (dec_cnt == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_READ;
                            byte_q  <= '0;
                            cnt_q   <= dec_cnt;
                            addr_q  <= dec_ea;
                            reg_q   <= dec_dst;
                        end
                    end
                end
                ST_READ: begin
                    if (rd_valid) begin
                        byte_q <= byte_q + CNT_W'(1);
                        addr_q <= addr_q + ADDR_W'(1);
                        if (word_full || last_byte) begin
                            wr_en_q   <= 1'b1;
                            wr_idx_q  <= reg_q;
                            wr_data_q <= merged;
                            reg_q     <= reg_q + RIDX_W'(1);
                        end
                        if (last_byte) state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output drive from registered state.
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = done_q;
        illegal = ill_q;
        rd_req  = (state_q == ST_READ);
        rd_addr = addr_q;
        wr_en   = wr_en_q;
        wr_idx  = wr_idx_q;
        wr_data = wr_data_q;
    end

    // R4: address held while a read is outstanding.
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> $stable(rd_addr));

    // R4: address steps by one after each returned byte.
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid) |=> (!rd_req || rd_addr == $past(rd_addr) + ADDR_W'(1)));

    // R8: a refused request stays idle and silent.
    a_r8_refused_idle: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !rd_req && !wr_en));

    // R10: a request during a transfer cannot raise illegal.
    a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_valid) |=> !illegal);

    // R11: done follows the final write or a zero-count request.
    a_r11_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) || $past(zero_go)));
endmodule

// File: tb/sim_lsw_seq.sv
module sim_lsw_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic [31:0] instr = '0, ra_val = '0, rb_val = '0;
    logic [6:0]  xcnt = '0;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data = '0;
    logic        busy, done, illegal, rd_req, wr_en;
    logic [31:0] rd_addr, wr_data;
    logic [4:0]  wr_idx;

    always #4 clk = ~clk;

    lsw_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .instr(instr),
        .ra_val(ra_val), .rb_val(rb_val), .xcnt(xcnt), .busy(busy), .done(done),
        .illegal(illegal), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    int total = 0, bad = 0, cyc = 0;
    logic [4:0]  e_idx [0:31];
    logic [31:0] e_dat [0:31];
    int          n_exp = 0, wr_cnt = 0, rd_seen = 0, lat = 0;
    logic [31:0] e_ea = '0;
    bit          wr_now = 0, wr_prev = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rd,
                                       input logic [4:0] ra, input logic [4:0] rb,
                                       input logic [9:0] xo, input logic b0);
        return {op, rd, ra, rb, xo, b0};
    endfunction

    // Memory model and write monitor.
    always @(negedge clk) begin
        wr_prev = wr_now;
        wr_now  = wr_en;
        if (wr_en) begin
            if (wr_cnt < n_exp) begin
                chk(wr_idx == e_idx[wr_cnt], "R7", "write index", 32'(wr_idx), 32'(e_idx[wr_cnt]));
                chk(wr_data == e_dat[wr_cnt], "R5/R6", "write data", wr_data, e_dat[wr_cnt]);
            end else begin
                chk(1'b0, "R11", "extra write", 32'(wr_cnt), 32'(n_exp));
            end
            wr_cnt++;
        end
        if (rd_valid) begin
            rd_valid = 1'b0;
            lat = $urandom % 3;
        end else if (rd_req) begin
            if (lat == 0) begin
                chk(rd_addr == e_ea + 32'(rd_seen), "R4", "read address", rd_addr, e_ea + 32'(rd_seen));
                rd_data  = mem_byte(rd_addr);
                rd_valid = 1'b1;
                rd_seen++;
            end else begin
                lat--;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_op(input logic [31:0] ins, input logic [31:0] ra_v,
                          input logic [31:0] rb_v, input logic [6:0] xc, input bit inject);
        logic [4:0]  rd_f = ins[25:21], ra_f = ins[20:16], nb_f = ins[15:11];
        bit          is_imm = ins[31:26] == 6'd31 && !ins[0] && ins[10:1] == 10'h255;
        bit          is_idx = ins[31:26] == 6'd31 && !ins[0] && ins[10:1] == 10'h215;
        logic [31:0] base = (ra_f == 0) ? 32'd0 : ra_v;
        int          cnt;
        bit          ill;
        int          waited = 0;
        ill = is_idx && (rd_f == ra_f || rd_f == nb_f || (rd_f == 0 && ra_f == 0));
        cnt = is_imm ? ((nb_f == 0) ? 32 : int'(nb_f)) : int'(xc);
        e_ea = is_imm ? base : base + rb_v;
        for (int k = 0; k < 32; k++) begin e_idx[k] = '0; e_dat[k] = '0; end
        n_exp = (is_imm || is_idx) && !ill ? (cnt + 3) / 4 : 0;
        for (int i = 0; i < cnt && n_exp > 0; i++) begin
            e_idx[i/4] = 5'(int'(rd_f) + i/4);
            e_dat[i/4] = e_dat[i/4] | (32'(mem_byte(e_ea + 32'(i))) << (24 - 8*(i%4)));
        end
        wr_cnt = 0; rd_seen = 0;
        @(negedge clk);
        instr = ins; ra_val = ra_v; rb_val = rb_v; xcnt = xc; start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
        #1;
        if (!(is_imm || is_idx)) begin
            chk(!busy && !illegal && !done, "R1", "unrecognised word taken", {busy, illegal, done}, 0);
            repeat (3) @(negedge clk);
            #1 chk(wr_cnt == 0 && rd_seen == 0, "R1", "activity on unrecognised word", wr_cnt + rd_seen, 0);
        end else if (ill) begin
            chk(illegal && !busy, "R8", "illegal pulse", {illegal, busy}, 2);
            repeat (3) @(negedge clk);
            #1 chk(wr_cnt == 0 && rd_seen == 0 && !illegal, "R8", "activity after refusal", wr_cnt + rd_seen, 0);
        end else if (cnt == 0) begin
            chk(done && !busy, "R9", "zero count done", {done, busy}, 2);
            repeat (3) @(negedge clk);
            #1 chk(wr_cnt == 0 && rd_seen == 0, "R9", "activity on zero count", wr_cnt + rd_seen, 0);
        end else begin
            chk(busy && !done, "R2/R3", "busy after accept", {busy, done}, 2);
            if (inject) begin
                repeat (2) @(negedge clk);
                instr = mk(6'd31, 5'd3, 5'd3, 5'd4, 10'h215, 1'b0);
                start_valid = 1'b1;
                @(negedge clk);
                start_valid = 1'b0;
                #1 chk(!illegal, "R10", "request taken while busy", illegal, 0);
            end
            while (!done && waited < 3000) begin
                @(negedge clk);
                #1 waited++;
            end
            chk(done, "R11", "done seen", done, 1);
            chk(wr_prev, "R11", "done one cycle after last write", wr_prev, 1);
            chk(!busy, "R11", "busy low at done", busy, 0);
            chk(wr_cnt == n_exp, "R11", "write count", wr_cnt, n_exp);
            chk(rd_seen == cnt, "R4", "read count", rd_seen, cnt);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk(!busy && !done && !illegal && !rd_req && !wr_en, "R11", "reset state",
               {busy, done, illegal, rd_req, wr_en}, 0);
        // Directed corners.
        run_op(mk(6'd31, 5'd30, 5'd5, 5'd0, 10'h255, 1'b0), 32'h1000, 0, 0, 0);      // R2 R7 32 bytes, wrap
        run_op(mk(6'd31, 5'd4, 5'd0, 5'd5, 10'h255, 1'b0), 32'hDEAD0000, 0, 0, 0);   // R2 R6 rA field 0
        run_op(mk(6'd31, 5'd9, 5'd2, 5'd8, 10'h255, 1'b0), 32'h2200, 0, 0, 0);       // R5 two full words
        run_op(mk(6'd31, 5'd1, 5'd2, 5'd3, 10'h215, 1'b0), 32'h300, 32'h45, 7'd0, 0);   // R9
        run_op(mk(6'd31, 5'd1, 5'd2, 5'd3, 10'h215, 1'b0), 32'h300, 32'h45, 7'd127, 0); // R3 max
        run_op(mk(6'd31, 5'd6, 5'd6, 5'd3, 10'h215, 1'b0), 32'h300, 32'h45, 7'd9, 0);   // R8 rD=rA
        run_op(mk(6'd31, 5'd6, 5'd2, 5'd6, 10'h215, 1'b0), 32'h300, 32'h45, 7'd9, 0);   // R8 rD=rB
        run_op(mk(6'd31, 5'd0, 5'd0, 5'd3, 10'h215, 1'b0), 32'h300, 32'h45, 7'd9, 0);   // R8 both 0
        run_op(mk(6'd31, 5'd1, 5'd2, 5'd3, 10'h215, 1'b1), 32'h300, 32'h45, 7'd9, 0);   // R1 bit 0 set
        run_op(mk(6'd30, 5'd1, 5'd2, 5'd3, 10'h215, 1'b0), 32'h300, 32'h45, 7'd9, 0);   // R1 wrong primary
        run_op(mk(6'd31, 5'd1, 5'd2, 5'd3, 10'h2D5, 1'b0), 32'h300, 32'h45, 7'd9, 0);   // R1 other extended
        run_op(mk(6'd31, 5'd28, 5'd2, 5'd3, 10'h215, 1'b0), 32'h7F0, 32'h11, 7'd22, 1); // R10 inject
        // Random mix.
        for (int n = 0; n < 40; n++) begin
            logic [9:0] xo;
            int sel = $urandom % 8;
            xo = (sel < 4) ? 10'h255 : (sel < 7) ? 10'h215 : 10'h295;
            run_op(mk(6'd31, 5'($urandom), 5'($urandom), 5'($urandom), xo, 1'b0),
                   $urandom, $urandom, 7'($urandom), ($urandom % 4) == 0);
        end
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule